// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Burst Line Refill

This block is a blocking, direct-mapped instruction cache for a core with an 8-bit byte address. The fetch side presents an address with a request strobe. The cache accepts the request only while it is idle. On a hit it returns the addressed byte one cycle later. On a miss it stalls, refills the whole line from a slow byte-wide memory, and then returns the byte. One cycle-wide hit or miss pulse is produced for each accepted request, so that a performance counter outside the block can count them.

A refill always starts at the line-aligned address and reads the bytes of the line in ascending order. Each byte read is a wait period. During that period the read strobe and the address are held steady, and the returned byte is taken in the last cycle of the period. The first byte of a line uses a long wait. Each later byte uses a shorter burst wait. The line size, set count and both wait lengths are parameters. The defaults are 4-byte lines, 4 sets, 10 cycles for the first byte and 5 cycles for each later byte.

The controller is a four-state machine:
- `ST_IDLE` accepts a request and looks it up.
- `ST_HIT` presents hit data.
- `ST_FILL` runs the memory reads.
- `ST_DONE` presents the refilled byte.

The transitions are:
- `ST_IDLE`→`ST_HIT` on a request that hits.
- `ST_IDLE`→`ST_FILL` on a request that misses.
- `ST_FILL`→`ST_DONE` when the last byte of the line is taken.
- `ST_HIT`→`ST_IDLE` and `ST_DONE`→`ST_IDLE` after one cycle.

Top module: `icache_dm`

## Requirements
- R1: After reset, every line is invalid, so the first fetch of any address misses. While reset is held, `fetch_idle`=1, `fetch_ready`=0 and `mem_rd`=0.
- R2: The address is split from the least significant bit upward:
  - the offset takes log2(line bytes) bits;
  - the index takes the next log2(sets) bits;
  - the tag takes the remaining bits.
  With the defaults, the offset is bits 1:0, the index is bits 3:2 and the tag is bits 7:4. Two addresses with the same index and different tags evict each other.
- R3: A hit is a request accepted while `fetch_idle`=1 whose indexed line is valid and holds the same tag. A hit raises `hit_pulse` in the cycle the request is accepted. `fetch_ready` is high for exactly the next cycle, with `fetch_data` equal to the addressed byte, and no memory read is started.
- R4: A miss raises `miss_pulse` in the cycle the request is accepted. The indexed line is overwritten, and when the refill completes its tag is updated and its valid bit is set. Afterwards, a fetch of any byte of that line hits.
- R5: A refill reads `mem_addr` = base, base+1, …, base+lines−1, in that order, where the base is the request address with its offset bits cleared. Each address stays constant for its whole wait period, with `mem_rd` held high.
- R6: The first byte of a refill waits FIRST_WAIT cycles and each later byte waits BURST_WAIT cycles. `mem_rdata` is taken only in the last cycle of each period. `mem_rd` is therefore high for FIRST_WAIT+(line bytes−1)·BURST_WAIT consecutive cycles, which is FIRST_WAIT alone for 1-byte lines.
- R7: After a miss, `fetch_ready` rises in the cycle right after the last `mem_rd` cycle and is high for one cycle. At that point `fetch_data` is the requested byte.
- R8: The cache is blocking. While `fetch_idle`=0 a request is ignored: it raises no pulse, it is not served later, and it does not disturb the refill in progress.
- R9: Every accepted request raises exactly one of `hit_pulse` and `miss_pulse`, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Fetch request strobe |
| fetch_addr | input | ADDR_W | Fetch byte address |
| fetch_idle | output | 1 | Cache can accept a request this cycle |
| fetch_ready | output | 1 | One-cycle pulse: `fetch_data` is valid |
| fetch_data | output | 8 | Returned instruction byte |
| hit_pulse | output | 1 | Accepted request hit |
| miss_pulse | output | 1 | Accepted request missed |
| mem_rd | output | 1 | Memory read strobe, held for the whole wait period |
| mem_addr | output | ADDR_W | Memory byte address being read |
| mem_rdata | input | 8 | Memory read data, taken in the last wait cycle |

## Verification
The assertions check the following on every cycle:
- a hit pulse is followed by a ready cycle with no memory read;
- a refill starts on a line-aligned address, and that address holds until the period's sample;
- the wait counter stays below its current limit, and the byte position steps by one per sample;
- no pulse appears while the cache is busy;
- the line is valid with the request's tag when the refilled byte is presented.

The bench's scenarios show the end-to-end behaviour. They check the exact wait-period lengths and the refill address order against a memory model that returns correct data only in the last wait cycle. They check hit and miss outcomes against a model of the tags, covering conflict eviction between tags, and they check that a request held during a refill is dropped.

// File: rtl/icache_pkg.sv
package icache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_FILL = 2'd2,
        ST_DONE = 2'd3
    } ic_state_e;

    // Number of address bits needed to select one of n items (0 when n <= 1)
    function automatic int sel_bits(input int n);
        return (n > 1) ? $clog2(n) : 0;
    endfunction

endpackage

// File: rtl/icache_addr_split.sv
module icache_addr_split #(
    parameter int ADDR_W   = 8,
    parameter int OFF_BITS = 2,
    parameter int IDX_BITS = 2,
    parameter int OFF_W    = 2,
    parameter int IDX_W    = 2,
    parameter int TAG_W    = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [OFF_W-1:0]  off,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);

    generate
        if (OFF_BITS > 0) begin : g_off
            assign off = addr[OFF_BITS-1:0];
        end else begin : g_no_off
            assign off = '0;
        end

        if (IDX_BITS > 0) begin : g_idx
            assign idx = addr[OFF_BITS +: IDX_BITS];
        end else begin : g_no_idx
            assign idx = '0;
        end
    endgenerate

    assign tag = addr[ADDR_W-1 -: TAG_W];

endmodule

// File: rtl/icache_line_store.sv
module icache_line_store #(
    parameter int NUM_SETS    = 4,
    parameter int BLOCK_BYTES = 4,
    parameter int TAG_W       = 4,
    parameter int IDX_W       = 2,
    parameter int OFF_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    // lookup
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [OFF_W-1:0] rd_off,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [7:0]       rd_byte,
    // line invalidate at refill start
    input  logic             inval_en,
    input  logic [IDX_W-1:0] inval_idx,
    // byte write during refill
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [7:0]       wr_data,
    // tag update and validate at refill end
    input  logic             commit_en,
    input  logic [IDX_W-1:0] commit_idx,
    input  logic [TAG_W-1:0] commit_tag
);

    logic             valid_q [NUM_SETS];
    logic [TAG_W-1:0] tag_q   [NUM_SETS];
    logic [7:0]       data_q  [NUM_SETS][BLOCK_BYTES];

    generate
        for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid_q[s] <= 1'b0;
                end else if (inval_en && inval_idx == IDX_W'(s)) begin
                    valid_q[s] <= 1'b0;
                end else if (commit_en && commit_idx == IDX_W'(s)) begin
                    valid_q[s] <= 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (commit_en && commit_idx == IDX_W'(s)) begin
                    tag_q[s] <= commit_tag;
                end
            end

            for (genvar b = 0; b < BLOCK_BYTES; b++) begin : g_byte
                always_ff @(posedge clk) begin
                    if (wr_en && wr_idx == IDX_W'(s) && wr_off == OFF_W'(b)) begin
                        data_q[s][b] <= wr_data;
                    end
                end
            end
        end
    endgenerate

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_byte  = data_q[rd_idx][rd_off];

    // A committed line reads back valid with the committed tag one cycle later
    AST_COMMIT_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en && rd_idx == commit_idx |=> rd_valid && rd_tag == $past(commit_tag)) // R4
        else $error("committed line not valid");

endmodule

// File: rtl/icache_fill_seq.sv
module icache_fill_seq #(
    parameter int BLOCK_BYTES = 4,
    parameter int FIRST_WAIT  = 10,
    parameter int BURST_WAIT  = 5,
    parameter int OFF_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             active,
    output logic [OFF_W-1:0] byte_idx,
    output logic             sample,
    output logic             last
);

    localparam int MAX_WAIT = (FIRST_WAIT > BURST_WAIT) ? FIRST_WAIT : BURST_WAIT;
    localparam int WC_W     = $clog2(MAX_WAIT + 1);
    localparam logic [WC_W-1:0] FIRST_LIM = WC_W'(FIRST_WAIT);
    localparam logic [WC_W-1:0] BURST_LIM = WC_W'(BURST_WAIT);
    localparam logic [OFF_W-1:0] LAST_BYTE = OFF_W'(BLOCK_BYTES - 1);

    logic              active_q;
    logic [WC_W-1:0]   wait_q;
    logic [OFF_W-1:0]  byte_q;
    logic [WC_W-1:0]   limit;

    // first byte of the line uses the long wait, later bytes the burst wait
    assign limit    = (byte_q == '0) ? FIRST_LIM : BURST_LIM;
    assign sample   = active_q && (wait_q == limit - 1'b1);
    assign last     = sample && (byte_q == LAST_BYTE);
    assign active   = active_q;
    assign byte_idx = byte_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            wait_q   <= '0;
            byte_q   <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            wait_q   <= '0;
            byte_q   <= '0;
        end else if (active_q) begin
            if (sample) begin
                wait_q <= '0;
                if (last) begin
                    active_q <= 1'b0;
                end else begin
                    byte_q <= byte_q + 1'b1;
                end
            end else begin
                wait_q <= wait_q + 1'b1;
            end
        end
    end

    AST_WAIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> wait_q < limit) // R6
        else $error("wait counter past its limit");

    AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        sample && !last |=> active_q && byte_q == $past(byte_q) + 1'b1 && wait_q == '0) // R5
        else $error("refill byte position did not advance by one");

    AST_START_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active_q) // R8
        else $error("refill started while another was running");

endmodule

// File: rtl/icache_dm.sv
module icache_dm
    import icache_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int BLOCK_BYTES = 4,
    parameter int NUM_SETS    = 4,
    parameter int FIRST_WAIT  = 10,
    parameter int BURST_WAIT  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_idle,
    output logic              fetch_ready,
    output logic [7:0]        fetch_data,
    output logic              hit_pulse,
    output logic              miss_pulse,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata
);

    localparam int OFF_BITS = sel_bits(BLOCK_BYTES);
    localparam int IDX_BITS = sel_bits(NUM_SETS);
    localparam int OFF_W    = (OFF_BITS > 0) ? OFF_BITS : 1;
    localparam int IDX_W    = (IDX_BITS > 0) ? IDX_BITS : 1;
    localparam int TAG_W    = ADDR_W - OFF_BITS - IDX_BITS;
    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((1 << OFF_BITS) - 1);

    ic_state_e         state_q, state_d;
    logic [ADDR_W-1:0] req_addr_q;

    logic [OFF_W-1:0]  f_off, r_off, look_off;
    logic [IDX_W-1:0]  f_idx, r_idx, look_idx;
    logic [TAG_W-1:0]  f_tag, r_tag, look_tag;

    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [7:0]        rd_byte;
    logic              lookup_hit;
    logic              accept;

    logic              fill_active;
    logic [OFF_W-1:0]  fill_byte;
    logic              fill_sample;
    logic              fill_last;

    icache_addr_split #(
        .ADDR_W(ADDR_W), .OFF_BITS(OFF_BITS), .IDX_BITS(IDX_BITS),
        .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_split_fetch (
        .addr(fetch_addr), .off(f_off), .idx(f_idx), .tag(f_tag)
    );

    icache_addr_split #(
        .ADDR_W(ADDR_W), .OFF_BITS(OFF_BITS), .IDX_BITS(IDX_BITS),
        .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_split_req (
        .addr(req_addr_q), .off(r_off), .idx(r_idx), .tag(r_tag)
    );

    // look up the incoming address while idle, the held request otherwise
    assign look_off = (state_q == ST_IDLE) ? f_off : r_off;
    assign look_idx = (state_q == ST_IDLE) ? f_idx : r_idx;
    assign look_tag = (state_q == ST_IDLE) ? f_tag : r_tag;

    assign lookup_hit = rd_valid && (rd_tag == look_tag);
    assign accept     = (state_q == ST_IDLE) && fetch_req;

    icache_line_store #(
        .NUM_SETS(NUM_SETS), .BLOCK_BYTES(BLOCK_BYTES),
        .TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (look_idx),
        .rd_off     (look_off),
        .rd_valid   (rd_valid),
        .rd_tag     (rd_tag),
        .rd_byte    (rd_byte),
        .inval_en   (miss_pulse),
        .inval_idx  (f_idx),
        .wr_en      (fill_sample),
        .wr_idx     (r_idx),
        .wr_off     (fill_byte),
        .wr_data    (mem_rdata),
        .commit_en  (fill_last),
        .commit_idx (r_idx),
        .commit_tag (r_tag)
    );

    icache_fill_seq #(
        .BLOCK_BYTES(BLOCK_BYTES), .FIRST_WAIT(FIRST_WAIT),
        .BURST_WAIT(BURST_WAIT), .OFF_W(OFF_W)
    ) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (miss_pulse),
        .active   (fill_active),
        .byte_idx (fill_byte),
        .sample   (fill_sample),
        .last     (fill_last)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // held request address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_addr_q <= '0;
        end else if (accept) begin
            req_addr_q <= fetch_addr;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fetch_req) begin
                    state_d = lookup_hit ? ST_HIT : ST_FILL;
                end
            end
            ST_HIT:  state_d = ST_IDLE;
            ST_FILL: begin
                if (fill_last) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        fetch_idle  = 1'b0;
        fetch_ready = 1'b0;
        hit_pulse   = 1'b0;
        miss_pulse  = 1'b0;
        mem_rd      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                fetch_idle = 1'b1;
                hit_pulse  = fetch_req && lookup_hit;
                miss_pulse = fetch_req && !lookup_hit;
            end
            ST_HIT:  fetch_ready = 1'b1;
            ST_FILL: mem_rd      = fill_active;
            ST_DONE: fetch_ready = 1'b1;
            default: ;
        endcase
        fetch_data = fetch_ready ? rd_byte : 8'h00;
    end

    assign mem_addr = (req_addr_q & ~OFF_MASK) | ADDR_W'(fill_byte);

    AST_HIT_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        hit_pulse |=> fetch_ready && !mem_rd) // R3
        else $error("hit not followed by ready");

    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ready |=> !fetch_ready) // R3
        else $error("ready held longer than one cycle");

    AST_FILL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        miss_pulse |=> mem_rd && (mem_addr & OFF_MASK) == '0) // R5
        else $error("refill did not start on the line base");

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && !fill_sample |=> mem_rd && $stable(mem_addr)) // R5
        else $error("memory address moved inside a wait period");

    AST_NO_PULSE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_idle |-> !hit_pulse && !miss_pulse) // R8
        else $error("pulse while busy");

    AST_DONE_LINE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DONE |-> rd_valid && rd_tag == r_tag) // R4
        else $error("refilled line not valid at response");

endmodule

// File: tb/icache_dm_test.sv
`timescale 1ns/1ps
module icache_dm_test;

    localparam int BB = 4;
    localparam int NS = 4;
    localparam int FW = 10;
    localparam int BW = 5;
    localparam int FILL_CYC = FW + (BB - 1) * BW;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       fetch_req;
    logic [7:0] fetch_addr;
    logic       fetch_idle, fetch_ready, hit_pulse, miss_pulse, mem_rd;
    logic [7:0] fetch_data, mem_addr, mem_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic       m_valid [NS];
    int         m_tag   [NS];
    logic [7:0] fill_log [8];
    int         log_n;
    logic       prev_rd;
    logic [7:0] prev_addr;
    int         wcnt;

    always #2 clk = ~clk;

    icache_dm #(
        .ADDR_W(8), .BLOCK_BYTES(BB), .NUM_SETS(NS),
        .FIRST_WAIT(FW), .BURST_WAIT(BW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_idle(fetch_idle), .fetch_ready(fetch_ready), .fetch_data(fetch_data),
        .hit_pulse(hit_pulse), .miss_pulse(miss_pulse),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] gold(input logic [7:0] a);
        return a * 8'd37 + 8'd11;
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
        end
    endtask

    // one clock; memory model returns good data only in the last wait cycle
    task automatic tick();
        int lim;
        @(posedge clk);
        #1;
        if (mem_rd) begin
            if (!prev_rd || mem_addr != prev_addr) begin
                wcnt = 0;
                if (log_n < 8) fill_log[log_n] = mem_addr;
                log_n++;
            end else begin
                wcnt++;
            end
            lim = (mem_addr % BB == 0) ? FW : BW;
            mem_rdata = (wcnt == lim - 1) ? gold(mem_addr) : (gold(mem_addr) ^ 8'hA5);
        end else begin
            mem_rdata = 8'h00;
        end
        prev_rd   = mem_rd;
        prev_addr = mem_addr;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        fetch_req = 1'b0;
        tick();
        tick();
        #1;
        chk(fetch_idle == 1'b1, "R1 idle in reset", int'(fetch_idle), 1);
        chk(fetch_ready == 1'b0, "R1 ready in reset", int'(fetch_ready), 0);
        chk(mem_rd == 1'b0, "R1 mem_rd in reset", int'(mem_rd), 0);
        rst_n = 1'b1;
        for (int s = 0; s < NS; s++) begin
            m_valid[s] = 1'b0;
            m_tag[s]   = 0;
        end
        tick();
    endtask

    task automatic do_fetch(input logic [7:0] a, input bit blk, input logic [7:0] ba,
                            input string why);
        int idx, tg, nrd, ncyc;
        bit exp_hit;
        logic [7:0] base;
        idx  = (int'(a) / BB) % NS;
        tg   = int'(a) / (BB * NS);
        base = a - 8'(int'(a) % BB);
        exp_hit = m_valid[idx] && m_tag[idx] == tg;
        fetch_addr = a;
        fetch_req  = 1'b1;
        #1;
        chk(fetch_idle == 1'b1, "R8 idle before request", int'(fetch_idle), 1);
        chk(hit_pulse == exp_hit, {why, " R3 hit_pulse"}, int'(hit_pulse), int'(exp_hit));
        chk(miss_pulse == !exp_hit, {why, " R4 miss_pulse"}, int'(miss_pulse), int'(!exp_hit));
        chk(hit_pulse != miss_pulse, "R9 exactly one pulse", int'(hit_pulse) + int'(miss_pulse), 1);
        log_n = 0;
        tick();
        if (blk) fetch_addr = ba;
        else     fetch_req = 1'b0;
        if (exp_hit) begin
            #1;
            chk(fetch_ready == 1'b1, "R3 ready after hit", int'(fetch_ready), 1);
            chk(fetch_data == gold(a), "R3 hit data", int'(fetch_data), int'(gold(a)));
            chk(mem_rd == 1'b0, "R3 no read on hit", int'(mem_rd), 0);
            fetch_req = 1'b0;
            tick();
            #1;
            chk(fetch_ready == 1'b0, "R3 ready one cycle", int'(fetch_ready), 0);
        end else begin
            nrd = 0;
            ncyc = 0;
            while (ncyc < 200) begin
                #1;
                if (fetch_ready) break;
                if (hit_pulse || miss_pulse)
                    chk(1'b0, "R8 pulse during refill", 1, 0);
                if (mem_rd) nrd++;
                ncyc++;
                tick();
            end
            chk(fetch_ready == 1'b1, "R7 ready after refill", int'(fetch_ready), 1);
            chk(nrd == FILL_CYC, "R6 read cycles", nrd, FILL_CYC);
            chk(ncyc == nrd, "R7 ready right after last read", ncyc, nrd);
            chk(fetch_data == gold(a), "R7 miss data", int'(fetch_data), int'(gold(a)));
            chk(log_n == BB, "R5 bytes read", log_n, BB);
            for (int k = 0; k < BB && k < 8; k++)
                chk(fill_log[k] == base + 8'(k), "R5 refill order", int'(fill_log[k]), int'(base) + k);
            m_valid[idx] = 1'b1;
            m_tag[idx]   = tg;
            fetch_req = 1'b0;
            tick();
            #1;
            chk(fetch_ready == 1'b0, "R7 ready one cycle", int'(fetch_ready), 0);
        end
    endtask

    initial begin
        logic [7:0] lf;
        rst_n = 1'b0;
        fetch_req = 1'b0;
        fetch_addr = 8'h00;
        mem_rdata = 8'h00;
        prev_rd = 1'b0;
        prev_addr = 8'h00;
        wcnt = 0;
        log_n = 0;
        do_reset();

        // R1 / R5: first fetch misses; miss on 0x0B reads 08,09,0A,0B
        do_fetch(8'h0B, 1'b0, 8'h00, "R1 cold");
        // R2: same line hits, same index other tag evicts
        do_fetch(8'h08, 1'b0, 8'h00, "R2 same line");
        do_fetch(8'h4A, 1'b0, 8'h00, "R2 conflict");
        do_fetch(8'h09, 1'b0, 8'h00, "R2 evicted");
        do_fetch(8'h04, 1'b0, 8'h00, "R2 other index");
        do_fetch(8'h0A, 1'b0, 8'h00, "R2 kept");

        // R8: request held during refill is dropped
        do_fetch(8'h4B, 1'b1, 8'h0B, "R8 blocking");
        do_fetch(8'h0B, 1'b0, 8'h00, "R8 not served");

        // sweep of the whole address space, ascending
        do_reset();
        for (int i = 0; i < 256; i++) do_fetch(8'(i), 1'b0, 8'h00, "R4 sweep");
        // strided sweep to force conflicts
        for (int i = 0; i < 256; i++) do_fetch(8'((i * 37) % 256), 1'b0, 8'h00, "R2 stride");

        // pseudo-random narrow range
        lf = 8'hA7;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            do_fetch(lf & 8'h37, 1'b0, 8'h00, "R9 random");
        end

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule